// File: doc/BRIEF.md
# Paged SPI Configuration Port

This block is a serial configuration slave. A host shifts fixed 24-bit frames into it with an active-low select, a serial clock and a data line. Each frame carries a 16-bit header and an 8-bit data byte. The header's top four bits are a read/write flag, a mode bit, a paging bit and a channel bit, followed by a 12-bit address. The block uses them to write a small configuration store or to return one byte serially.

Two kinds of access exist. Paged access goes through a page number held in the block. That number is set once by a page-select frame and then serves any number of later frames. Direct access reaches two per-channel configuration pages, decimation and power detector, in a single frame without touching the stored page. The contents of those two pages leave the block as parallel buses for the datapaths that use them.

All three serial inputs are sampled with the system clock. The serial clock must therefore run well below the system clock.

Top module: `spi_cfg_port`

## Requirements
- R1: A frame is 24 bits, MSB first, sampled on rising serial-clock edges while `sen_n` is low. Header bit 15 is R/W, bit 14 is M, bit 13 is P, bit 12 is CH and bits 11..0 are the address A. The last 8 bits are the data byte.
- R2: A write takes effect only after the 24th bit. Raising `sen_n` before that discards the frame with no change. Clock edges after the 24th bit are ignored.
- R3: A frame with R/W=0, M=1, P=0 and CH=1 is a direct write. A10=0 selects the decimation page and A10=1 the power-detector page. A11=0 selects channel A and A11=1 channel B. The offset is A[1:0], and A[9:2] must be zero. The byte lands in `dec_cfg` or `pdet_cfg` at byte index (A11*4 + offset). For example, header 5001h with data 02h sets `dec_cfg[15:8]` to 02h.
- R4: A frame with R/W=0, M=0 and A=010h loads the page number from data bits [1:0].
- R5: A frame with R/W=0, M=1 and P=1 writes the paged store at (page, channel, A[1:0]). CH=1 means channel A and CH=0 means channel B. A page of 2 or more, or a nonzero A[11:2], discards the write.
- R6: A frame with R/W=1, M=1 and P=1 returns the addressed paged byte on `sdout`, MSB first, during bits 17..24. `sdout` changes on falling serial-clock edges. The data field on `sdin` is ignored.
- R7: The page number persists across frames. Repeated reads and writes use it without another page-select frame.
- R8: `sdout` is low during the 16 header bits, outside a frame and for every frame that is not a valid paged read. A read of a missing page or offset returns 00h.
- R9: Reset clears the page number, the paged store and both direct pages to zero.
- R10: Any other header, such as R/W=1 with P=0, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idle low |
| sen_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data in |
| sdout | output | 1 | Serial read data out |
| dec_cfg | output | 64 | Decimation page bytes; byte index = channel*4 + offset |
| pdet_cfg | output | 64 | Power-detector page bytes; same indexing |

## Verification
The hardest case to reach is a read that depends on a page number set several frames earlier, because the stored page cannot be seen at the ports. The stimulus writes distinct bytes into two pages and then flips the page back and forth. It also selects a page that does not exist. The readback of one unchanged offset must then track each switch. Aborted frames cut off at 20 and 23 bits, and reads of the direct pages, confirm that the parallel outputs stay unchanged.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    localparam int FRAME_LEN = 24;
    localparam int HDR_LEN   = 16;
    localparam int DATA_LEN  = 8;
    localparam int ADDR_LEN  = 12;
    // header bit positions (counted inside the 16-bit header)
    localparam int B_RW = 15;
    localparam int B_M  = 14;
    localparam int B_P  = 13;
    localparam int B_CH = 12;

    typedef enum logic [2:0] {
        K_NONE,
        K_PSEL,
        K_DIG,
        K_DEC,
        K_PDET
    } kind_e;
endpackage

// File: rtl/spi_cfg_shifter.sv
module spi_cfg_shifter import spi_cfg_pkg::*; (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_i,
    input  logic                sen_n_i,
    input  logic                sdin_i,
    input  logic [DATA_LEN-1:0] rd_byte_i,
    output logic [HDR_LEN-1:0]  hdr_o,
    output logic                hdr_ok_o,
    output logic                commit_o,
    output logic [DATA_LEN-1:0] data_o,
    output logic                sdout_o
);
    localparam int CNT_W = $clog2(FRAME_LEN + 1);
    localparam int SEL_W = $clog2(DATA_LEN);

    typedef struct packed {
        logic                 sclk_m, sclk_s, sclk_p;
        logic                 sen_m, sen_s;
        logic                 sdin_m, sdin_s;
        logic [CNT_W-1:0]     cnt;
        logic [FRAME_LEN-1:0] sh;
        logic [HDR_LEN-1:0]   hdr;
        logic                 commit;
        logic                 sdout;
    } sh_st_t;

    sh_st_t q, d;
    logic rise, fall;
    logic [SEL_W-1:0] bit_sel;

    always_comb begin
        d        = q;
        d.commit = 1'b0;
        d.sclk_m = sclk_i;  d.sclk_s = q.sclk_m;  d.sclk_p = q.sclk_s;
        d.sen_m  = sen_n_i; d.sen_s  = q.sen_m;
        d.sdin_m = sdin_i;  d.sdin_s = q.sdin_m;
        rise     = q.sclk_s & ~q.sclk_p;
        fall     = ~q.sclk_s & q.sclk_p;
        bit_sel  = SEL_W'(CNT_W'(FRAME_LEN - 1) - q.cnt);
        if (q.sen_s) begin
            d.cnt   = '0;
            d.sdout = 1'b0;
        end else begin
            if (rise && q.cnt < CNT_W'(FRAME_LEN)) begin
                d.sh  = {q.sh[FRAME_LEN-2:0], q.sdin_s};
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(HDR_LEN - 1))
                    d.hdr = {q.sh[HDR_LEN-2:0], q.sdin_s};
                if (q.cnt == CNT_W'(FRAME_LEN - 1))
                    d.commit = 1'b1;
            end
            if (fall) begin
                if (q.cnt >= CNT_W'(HDR_LEN) && q.cnt < CNT_W'(FRAME_LEN))
                    d.sdout = rd_byte_i[bit_sel];
                else
                    d.sdout = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.sen_m <= 1'b1;
            q.sen_s <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign hdr_o    = q.hdr;
    assign hdr_ok_o = (q.cnt >= CNT_W'(HDR_LEN));
    assign commit_o = q.commit;
    assign data_o   = q.sh[DATA_LEN-1:0];
    assign sdout_o  = q.sdout;

    a_r8_sdout_quiet_header: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt < CNT_W'(HDR_LEN)) |-> !q.sdout);
    a_r2_commit_at_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
        q.commit |-> (q.cnt == CNT_W'(FRAME_LEN)));
    a_r2_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.commit |=> !q.commit);
    a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(FRAME_LEN));
endmodule

// File: rtl/spi_cfg_decode.sv
module spi_cfg_decode import spi_cfg_pkg::*; #(
    parameter int               OFS_W     = 2,
    parameter int               PAGE_W    = 2,
    parameter int               NUM_PAGES = 2,
    parameter logic [11:0]      PSEL_ADDR = 12'h010,
    parameter int               IDX_W     = 4
) (
    input  logic [HDR_LEN-1:0] hdr_i,
    input  logic [PAGE_W-1:0]  page_i,
    output kind_e              kind_o,
    output logic [IDX_W-1:0]   idx_o
);
    logic                rw, m, p, ch;
    logic [ADDR_LEN-1:0] addr;
    logic [OFS_W-1:0]    ofs;
    logic                paged_ofs_ok, dir_ofs_ok;

    always_comb begin
        rw           = hdr_i[B_RW];
        m            = hdr_i[B_M];
        p            = hdr_i[B_P];
        ch           = hdr_i[B_CH];
        addr         = hdr_i[ADDR_LEN-1:0];
        ofs          = addr[OFS_W-1:0];
        paged_ofs_ok = (addr[ADDR_LEN-1:OFS_W] == '0);
        dir_ofs_ok   = (addr[9:OFS_W] == '0);
        kind_o       = K_NONE;
        idx_o        = '0;
        if (!m) begin
            if (!rw && addr == PSEL_ADDR)
                kind_o = K_PSEL;
        end else if (p) begin
            if (paged_ofs_ok && int'(page_i) < NUM_PAGES) begin
                kind_o = K_DIG;
                // channel index 0 = A (CH=1), 1 = B (CH=0)
                idx_o  = IDX_W'({page_i, ~ch, ofs});
            end
        end else if (ch && !rw && dir_ofs_ok) begin
            kind_o = addr[10] ? K_PDET : K_DEC;
            idx_o  = IDX_W'({addr[11], ofs});
        end
    end
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs import spi_cfg_pkg::*; #(
    parameter int OFS_W     = 2,
    parameter int PAGE_W    = 2,
    parameter int NUM_PAGES = 2,
    parameter int IDX_W     = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 commit_i,
    input  logic                                 hdr_ok_i,
    input  logic                                 rw_i,
    input  kind_e                                kind_i,
    input  logic [IDX_W-1:0]                     idx_i,
    input  logic [DATA_LEN-1:0]                  data_i,
    output logic [DATA_LEN-1:0]                  rd_byte_o,
    output logic [PAGE_W-1:0]                    page_o,
    output logic [2*(1<<OFS_W)-1:0][DATA_LEN-1:0] dec_o,
    output logic [2*(1<<OFS_W)-1:0][DATA_LEN-1:0] pdet_o
);
    localparam int REGS  = 1 << OFS_W;
    localparam int DIR_N = 2 * REGS;
    localparam int DIG_N = NUM_PAGES * DIR_N;

    typedef struct packed {
        logic [PAGE_W-1:0]                page;
        logic [DIG_N-1:0][DATA_LEN-1:0]   dig;
        logic [DIR_N-1:0][DATA_LEN-1:0]   dec;
        logic [DIR_N-1:0][DATA_LEN-1:0]   pdet;
    } rf_st_t;

    rf_st_t q, d;

    always_comb begin
        d = q;
        if (commit_i && !rw_i) begin
            unique case (kind_i)
                K_PSEL:  d.page                = data_i[PAGE_W-1:0];
                K_DIG:   d.dig[idx_i]          = data_i;
                K_DEC:   d.dec[idx_i[OFS_W:0]]  = data_i;
                K_PDET:  d.pdet[idx_i[OFS_W:0]] = data_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_byte_o = (hdr_ok_i && rw_i && kind_i == K_DIG) ? q.dig[idx_i] : '0;
    assign page_o    = q.page;
    assign dec_o     = q.dec;
    assign pdet_o    = q.pdet;

    a_r2_store_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(q));
    a_r10_read_keeps_store: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && rw_i) |=> $stable(q));
    a_r5_page_range: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == K_DIG) |-> (int'(idx_i) < DIG_N));
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port import spi_cfg_pkg::*; #(
    parameter int          OFS_W     = 2,
    parameter int          PAGE_W    = 2,
    parameter int          NUM_PAGES = 2,
    parameter logic [11:0] PSEL_ADDR = 12'h010
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sclk,
    input  logic                          sen_n,
    input  logic                          sdin,
    output logic                          sdout,
    output logic [2*(1<<OFS_W)*8-1:0]     dec_cfg,
    output logic [2*(1<<OFS_W)*8-1:0]     pdet_cfg
);
    localparam int REGS  = 1 << OFS_W;
    localparam int DIR_N = 2 * REGS;
    localparam int IDX_W = $clog2(NUM_PAGES * DIR_N);

    logic [HDR_LEN-1:0]              hdr;
    logic                            hdr_ok, commit;
    logic [DATA_LEN-1:0]             wdata, rd_byte;
    kind_e                           kind;
    logic [IDX_W-1:0]                idx;
    logic [PAGE_W-1:0]               page;
    logic [DIR_N-1:0][DATA_LEN-1:0]  dec_w, pdet_w;

    spi_cfg_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sen_n_i(sen_n), .sdin_i(sdin),
        .rd_byte_i(rd_byte), .hdr_o(hdr), .hdr_ok_o(hdr_ok), .commit_o(commit),
        .data_o(wdata), .sdout_o(sdout)
    );

    spi_cfg_decode #(
        .OFS_W(OFS_W), .PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES),
        .PSEL_ADDR(PSEL_ADDR), .IDX_W(IDX_W)
    ) u_dec (
        .hdr_i(hdr), .page_i(page), .kind_o(kind), .idx_o(idx)
    );

    spi_cfg_regs #(
        .OFS_W(OFS_W), .PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .commit_i(commit), .hdr_ok_i(hdr_ok),
        .rw_i(hdr[B_RW]), .kind_i(kind), .idx_i(idx), .data_i(wdata),
        .rd_byte_o(rd_byte), .page_o(page), .dec_o(dec_w), .pdet_o(pdet_w)
    );

    assign dec_cfg  = dec_w;
    assign pdet_cfg = pdet_w;
endmodule

// File: tb/tb_spi_cfg_port.sv
module tb_spi_cfg_port;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sen_n = 1'b1;
    logic        sdin = 1'b0;
    logic        sdout;
    logic [63:0] dec_cfg, pdet_cfg;

    always #4 clk = ~clk;

    spi_cfg_port dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sen_n(sen_n), .sdin(sdin),
        .sdout(sdout), .dec_cfg(dec_cfg), .pdet_cfg(pdet_cfg)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    typedef struct { logic [23:0] exp; string req; } item_t;
    item_t sbq[$];

    logic [7:0] dig_m [2][2][4];
    logic [7:0] dec_m [8];
    logic [7:0] pdet_m[8];
    int         page_m;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic void model_clear();
        page_m = 0;
        for (int i = 0; i < 8; i++) begin dec_m[i] = '0; pdet_m[i] = '0; end
        for (int a = 0; a < 2; a++) for (int b = 0; b < 2; b++)
            for (int c = 0; c < 4; c++) dig_m[a][b][c] = '0;
    endfunction

    // expected effect of one complete frame, from the requirement list
    function automatic logic [7:0] model_apply(logic [23:0] f);
        logic rw, m, p, ch;
        logic [11:0] a;
        logic [7:0] dt, rd;
        int ci, ix;
        rw = f[23]; m = f[22]; p = f[21]; ch = f[20]; a = f[19:8]; dt = f[7:0];
        rd = 8'h00;
        if (!m) begin
            if (!rw && a == 12'h010) page_m = int'(dt[1:0]);
        end else if (p) begin
            if (a < 12'd4 && page_m < 2) begin
                ci = ch ? 0 : 1;
                if (rw) rd = dig_m[page_m][ci][a[1:0]];
                else    dig_m[page_m][ci][a[1:0]] = dt;
            end
        end else if (ch && !rw && a[9:2] == 8'h00) begin
            ix = int'(a[11]) * 4 + int'(a[1:0]);
            if (a[10]) pdet_m[ix] = dt;
            else       dec_m[ix]  = dt;
        end
        return rd;
    endfunction

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: sends nbits of a frame; complete frames push the expected sdout stream
    task automatic frame(logic [23:0] f, int nbits, string req);
        item_t it;
        if (nbits == 24) begin
            it.exp = {16'h0000, model_apply(f)};
            it.req = req;
            sbq.push_back(it);
        end
        sen_n = 1'b0;
        wait_clk(HALF);
        for (int i = 23; i >= 24 - nbits; i--) begin
            sdin = f[i];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        sen_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic check_cfg(string req);
        logic [63:0] ed, ep;
        for (int i = 0; i < 8; i++) begin
            ed[8*i +: 8] = dec_m[i];
            ep[8*i +: 8] = pdet_m[i];
        end
        chk(req, dec_cfg, ed);
        chk(req, pdet_cfg, ep);
    endtask

    // monitor: collects sdout at each rising serial clock of a frame
    int          mon_n = 0;
    logic [23:0] mon_sh = '0;
    always @(posedge sclk or posedge sen_n) begin
        if (sen_n) begin
            mon_n = 0;
        end else begin
            mon_sh = {mon_sh[22:0], sdout};
            mon_n++;
            if (mon_n == 24) begin
                if (sbq.size() == 0) begin
                    chk("R1", 64'(mon_sh), 64'hDEAD);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    chk(it.req, 64'(mon_sh), 64'(it.exp));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_err++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        model_clear();
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(4);
        // R9 reset state
        chk("R9", 64'(sdout), 64'h0);
        check_cfg("R9");

        // R1 R3 direct writes, all four page/channel combinations
        frame(24'h5001_02, 24, "R8");
        chk("R1 R3", 64'(dec_cfg[15:8]), 64'h02);
        frame(24'h5803_A5, 24, "R8");
        frame(24'h5402_3C, 24, "R8");
        frame(24'h5C00_81, 24, "R8");
        check_cfg("R3");
        // R3 offset beyond the page is ignored
        frame(24'h5004_FF, 24, "R8");
        check_cfg("R3");
        // R10 read flag on a direct header changes nothing, sdout stays low
        frame(24'hD001_77, 24, "R10");
        check_cfg("R10");
        // R2 aborted frames
        frame(24'h5002_EE, 20, "R2");
        frame(24'h5402_EE, 23, "R2");
        check_cfg("R2");

        // R4 R5 page select, paged writes on both channels
        frame(24'h0010_01, 24, "R4");
        frame(24'h7001_11, 24, "R5");
        frame(24'h6001_22, 24, "R5");
        frame(24'h7003_33, 24, "R5");
        // R6 R7 several reads from the held page, data field ignored
        frame(24'hF001_00, 24, "R6");
        frame(24'hE001_00, 24, "R6");
        frame(24'hF003_FF, 24, "R7");
        // R4 R7 page switch and back
        frame(24'h0010_00, 24, "R4");
        frame(24'h7001_44, 24, "R5");
        frame(24'hF001_00, 24, "R7");
        frame(24'h0010_01, 24, "R4");
        frame(24'hF001_00, 24, "R7");
        // R5 R8 missing page: write dropped, read gives zero
        frame(24'h0010_02, 24, "R4");
        frame(24'h7001_99, 24, "R5");
        frame(24'hF001_00, 24, "R8");
        frame(24'h0010_01, 24, "R4");
        frame(24'hF001_00, 24, "R5");
        // R5 paged offset out of range
        frame(24'h7004_55, 24, "R5");
        frame(24'hF004_00, 24, "R8");
        frame(24'hF003_00, 24, "R7");
        check_cfg("R3");

        // R9 second reset clears everything, page back to zero
        rst_n = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        model_clear();
        wait_clk(4);
        check_cfg("R9");
        frame(24'hF001_00, 24, "R9");
        frame(24'h0010_01, 24, "R9");
        frame(24'hF001_00, 24, "R9");

        wait_clk(10);
        chk("R6", 64'(sbq.size()), 64'h0);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule